// File: doc/BRIEF.md
# Half-Step Clock Divider

This block derives a divided clock from a system clock. A 3-bit select picks one of six ratios: pass-through, divide by 2, 3, 4, 5.5 or 6. Every integer ratio gives an even split of high and low time, odd ratios included. The 5.5 ratio gives a period of eleven input half-periods. Output edges fall on both rising and falling input edges, so no faster clock is needed.

Internally the block counts input half-periods. It decides two output half-slots on each rising input edge. One flop clocked on the rising edge and one clocked on the falling edge each toggle one term of an XOR pair. A new select value is taken up only where an output period begins, so a change never cuts a phase short. The two unused select codes run the divider as pass-through and set an error flag that holds until reset.

Top module: `ckdiv_half`

## Requirements
- R1: With select 000 the output has the input clock's waveform: period 10 ns at a 100 MHz input, high 5 ns.
- R2: Select 001, 010 and 011 give periods of 4, 6 and 8 input half-periods, with high and low time each half of the period.
- R3: Select 100 gives a period of exactly 11 input half-periods, with 6 half-periods high and 5 low.
- R4: Select 101 gives a period of 12 input half-periods, with 6 high and 6 low.
- R5: Select 110 and 111 are reserved and produce the same waveform as select 000.
- R6: `bad_sel_o` is low after reset and stays low while only valid codes are applied. It goes high at the first rising input edge that samples a reserved code, and it stays high until reset, whatever codes follow.
- R7: Across a select change, every output high phase and every output low phase has the length of a phase of either the old ratio or the new ratio. No runt or shortened phase appears.
- R8: The first rising output edge after a new select is sampled begins a period that matches the new ratio exactly in both period and high time.
- R9: While `rst_ni` is low, `clk_o` and `bad_sel_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; both of its edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Ratio select, sampled on rising edges of `clk_i` |
| clk_o | output | 1 | Divided clock |
| bad_sel_o | output | 1 | Sticky flag for a reserved select code |

## Verification
The bench builds the block with its default package constants: a 3-bit select and a 4-bit half-period index. With a 3-bit select there are only eight codes, so every ordered pair of start and target code (64 transitions) can be driven. For each transition the bench measures the first new period edge to edge, and it checks the length of every output phase across the switch. This covers the alignment of the odd 5.5 ratio to alternating input edges, and switches into and out of both reserved codes.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;
    // width of the ratio select field
    localparam int SEL_W  = 3;
    // largest period in input half-periods
    localparam int MAX_HALVES = 12;
    // width of the half-period index
    localparam int HALF_W = $clog2(MAX_HALVES + 1);

    typedef logic [HALF_W-1:0] half_t;

    // one ratio: period and high time, both in input half-periods
    typedef struct packed {
        half_t per;
        half_t hi;
    } ratio_t;

    // registered state of the rising-edge sequencer
    typedef struct packed {
        half_t  ph;    // half-period index of the next slot to emit
        ratio_t cfg;   // ratio of the period in progress
        logic   tog;   // rising-edge term of the output XOR pair
        logic   fall;  // level for the coming falling-edge slot
        logic   bad;   // sticky reserved-code flag
    } seq_t;
endpackage

// File: rtl/ckdiv_decode.sv
`timescale 1ns/1ps
module ckdiv_decode
    import ckdiv_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output ratio_t           cfg_o,
    output logic             reserved_o
);
    half_t per;

    always_comb begin
        reserved_o = 1'b0;
        case (sel_i)
            3'd0:    per = half_t'(2);
            3'd1:    per = half_t'(4);
            3'd2:    per = half_t'(6);
            3'd3:    per = half_t'(8);
            3'd4:    per = half_t'(11);
            3'd5:    per = half_t'(12);
            default: begin
                per        = half_t'(2);
                reserved_o = 1'b1;
            end
        endcase
        cfg_o.per = per;
        // high time rounds up, so an odd period is one half-period longer high
        cfg_o.hi  = half_t'((per + half_t'(1)) >> 1);
    end
endmodule

// File: rtl/ckdiv_seq.sv
`timescale 1ns/1ps
module ckdiv_seq
    import ckdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  ratio_t cfg_new_i,
    input  logic   reserved_i,
    input  logic   fall_term_i,
    output logic   tog_o,
    output logic   fall_o,
    output logic   bad_o,
    output half_t  ph_o,
    output half_t  per_o
);
    seq_t   st_d, st_q;
    ratio_t cfg0, cfg1;
    half_t  n1;
    logic   h0, h1;

    always_comb begin
        st_d = st_q;
        // slot for the high input phase; a new ratio is taken only at index 0
        cfg0 = (st_q.ph == '0) ? cfg_new_i : st_q.cfg;
        h0   = (st_q.ph < cfg0.hi);
        n1   = (st_q.ph == cfg0.per - half_t'(1)) ? '0 : st_q.ph + half_t'(1);
        // slot for the low input phase; a period may begin here on odd ratios
        cfg1 = (n1 == '0) ? cfg_new_i : cfg0;
        h1   = (n1 < cfg1.hi);
        st_d.ph   = (n1 == cfg1.per - half_t'(1)) ? '0 : n1 + half_t'(1);
        st_d.cfg  = cfg1;
        st_d.tog  = h0 ^ fall_term_i;
        st_d.fall = h1;
        st_d.bad  = st_q.bad | reserved_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ph: '0, cfg: '{per: half_t'(2), hi: half_t'(1)},
                       tog: 1'b0, fall: 1'b0, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tog_o  = st_q.tog;
    assign fall_o = st_q.fall;
    assign bad_o  = st_q.bad;
    assign ph_o   = st_q.ph;
    assign per_o  = st_q.cfg.per;
endmodule

// File: rtl/ckdiv_edge.sv
`timescale 1ns/1ps
module ckdiv_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tog_i,
    input  logic fall_i,
    output logic fall_term_o,
    output logic clk_o
);
    logic term_d, term_q;

    // set the falling-edge term so that the XOR pair shows fall_i
    always_comb begin
        term_d = fall_i ^ tog_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            term_q <= 1'b0;
        end else begin
            term_q <= term_d;
        end
    end

    assign fall_term_o = term_q;
    // only one term moves at each input edge, so the output cannot glitch
    assign clk_o       = tog_i ^ term_q;
endmodule

// File: rtl/ckdiv_half.sv
`timescale 1ns/1ps
module ckdiv_half
    import ckdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output logic             clk_o,
    output logic             bad_sel_o
);
    ratio_t cfg_new;
    logic   reserved, tog, fall, fall_term;
    half_t  cur_ph, cur_per;

    ckdiv_decode u_dec (
        .sel_i      (sel_i),
        .cfg_o      (cfg_new),
        .reserved_o (reserved)
    );

    ckdiv_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_new_i   (cfg_new),
        .reserved_i  (reserved),
        .fall_term_i (fall_term),
        .tog_o       (tog),
        .fall_o      (fall),
        .bad_o       (bad_sel_o),
        .ph_o        (cur_ph),
        .per_o       (cur_per)
    );

    ckdiv_edge u_edge (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tog_i       (tog),
        .fall_i      (fall),
        .fall_term_o (fall_term),
        .clk_o       (clk_o)
    );
endmodule

// File: rtl/ckdiv_half_chk.sv
`timescale 1ns/1ps
module ckdiv_half_chk
    import ckdiv_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [SEL_W-1:0] sel_i,
    input logic             clk_o,
    input logic             bad_sel_o,
    input half_t            cur_per,
    input half_t            cur_ph
);
    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_sel_o |=> bad_sel_o);

    // R6
    flag_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 3'd6 || sel_i == 3'd7) |=> bad_sel_o);

    // R7
    index_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_ph < cur_per);

    // R3
    legal_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_per inside {4'd2, 4'd4, 4'd6, 4'd8, 4'd11, 4'd12});

    // R9
    always @(negedge clk_i) begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (clk_o == 1'b0 && bad_sel_o == 1'b0);
        end
    end
endmodule

bind ckdiv_half ckdiv_half_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .clk_o     (clk_o),
    .bad_sel_o (bad_sel_o),
    .cur_per   (cur_per),
    .cur_ph    (cur_ph)
);

// File: tb/ckdiv_half_test.sv
`timescale 1ns/1ps
module ckdiv_half_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       clk_o, bad;
    int         checks = 0;
    int         fails = 0;
    bit         seen_reserved = 1'b0;

    always #5 clk = ~clk;

    ckdiv_half uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .sel_i     (sel),
        .clk_o     (clk_o),
        .bad_sel_o (bad)
    );

    // period in input half-periods for a select code
    function automatic int per_of(int c);
        case (c)
            1: return 4;
            2: return 6;
            3: return 8;
            4: return 11;
            5: return 12;
            default: return 2;
        endcase
    endfunction

    function automatic int hi_of(int c);
        return (per_of(c) + 1) / 2;
    endfunction

    function automatic string req_of(int c);
        case (c)
            0: return "R1";
            1, 2, 3: return "R2";
            4: return "R3";
            5: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // phase monitor: each phase must match the old or the new ratio (R7)
    int  hi_a = 1, lo_a = 1, hi_b = 1, lo_b = 1;
    bit  mon_en = 1'b0;
    bit  mon_first = 1'b1;
    realtime last_edge = 0.0;

    always @(clk_o) begin
        if (mon_en) begin
            if (!mon_first) begin
                int ps;
                int h;
                ps = $rtoi(($realtime - last_edge) * 1000.0 + 0.5);
                h  = ps / 5000;
                if (clk_o == 1'b0)
                    check((ps % 5000 == 0) && (h == hi_a || h == hi_b), "R7",
                          "high phase ps", ps, hi_b * 5000);
                else
                    check((ps % 5000 == 0) && (h == lo_a || h == lo_b), "R7",
                          "low phase ps", ps, lo_b * 5000);
            end
            mon_first = 1'b0;
        end
        last_edge = $realtime;
    end

    // switch to code c at a safe point and measure the first new period (R8)
    task automatic go(int c);
        realtime t0, t1, t2;
        @(negedge clk);
        #1;
        hi_b = hi_of(c);
        lo_b = per_of(c) - hi_of(c);
        sel  = 3'(c);
        @(posedge clk);
        #1;
        if (c >= 6) begin
            seen_reserved = 1'b1;
            check(bad == 1'b1, "R6", "flag after reserved code", int'(bad), 1);
        end else if (!seen_reserved) begin
            check(bad == 1'b0, "R6", "flag with valid codes only", int'(bad), 0);
        end else begin
            check(bad == 1'b1, "R6", "flag held after valid code", int'(bad), 1);
        end
        @(posedge clk_o);
        t0 = $realtime;
        @(negedge clk_o);
        t1 = $realtime;
        @(posedge clk_o);
        t2 = $realtime;
        check($rtoi((t1 - t0) * 1000.0 + 0.5) == hi_of(c) * 5000,
              req_of(c), "R8 first high time ps",
              $rtoi((t1 - t0) * 1000.0 + 0.5), hi_of(c) * 5000);
        check($rtoi((t2 - t0) * 1000.0 + 0.5) == per_of(c) * 5000,
              req_of(c), "R8 first period ps",
              $rtoi((t2 - t0) * 1000.0 + 0.5), per_of(c) * 5000);
        hi_a = hi_b;
        lo_a = lo_b;
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R9: quiet outputs while held in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #2;
            check(clk_o == 1'b0, "R9", "clk_o in reset", int'(clk_o), 0);
            check(bad == 1'b0, "R9", "flag in reset", int'(bad), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_first = 1'b1;
        mon_en = 1'b1;
        // every valid code from the bypass start, flag must stay low (R6)
        for (int c = 0; c < 6; c++) go(c);
        // exhaustive ordered pairs of start and target code
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                go(a);
                go(b);
            end
        end
        go(2);
        check(bad == 1'b1, "R6", "flag before reset", int'(bad), 1);
        // second reset clears the flag and quiets the output
        mon_en = 1'b0;
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check(clk_o == 1'b0, "R9", "clk_o right after reset", int'(clk_o), 0);
        check(bad == 1'b0, "R9", "flag right after reset", int'(bad), 0);
        repeat (3) @(posedge clk);
        #2;
        check(clk_o == 1'b0, "R9", "clk_o held in reset", int'(clk_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        seen_reserved = 1'b0;
        hi_a = hi_of(2);
        lo_a = per_of(2) - hi_of(2);
        go(4);
        go(0);
        check(bad == 1'b0, "R6", "flag cleared by reset", int'(bad), 0);
        finish_run();
    end
endmodule